// File: doc/BRIEF.md
# Transition Firing Report Counter

This block sits beside one transition of a hardware net-execution core and keeps a tally of how many times that transition has fired, so that a host processor can collect the reports at its own pace. The core delivers a one-cycle fire pulse for each firing. The host consumes one report per one-cycle read pulse. The count saturates at its top value: a firing that arrives there is dropped, and a sticky overflow flag records the loss.

A mode input selects between a reporting mode and a silent mode for each transition. In silent mode the counter is left alone. Fire and read pulses have no effect, the count holds its value, and the not-empty and interrupt outputs stay low. The interrupt request is the not-empty indication gated by an interrupt-enable input. A parameter can move it onto a register stage.

Top module: `fire_report_queue`

## Requirements
- R1: While reset is asserted and directly after it, count_o is 0, overflow_o is 0, not_empty_o is 0 and irq_o is 0.
- R2: With mode_i = 1 (reporting), a fire_i pulse without read_i increments count_o by one at the next rising clock edge, provided count_o is below its maximum 2^CNT_W-1.
- R3: With mode_i = 1, a read_i pulse without fire_i decrements a non-zero count_o by one at the next rising edge.
- R4: With mode_i = 1, a read_i pulse without fire_i while count_o is 0 is ignored: count_o stays 0.
- R5: With mode_i = 1, fire_i and read_i asserted in the same cycle leave count_o unchanged, at any count including 0 and the maximum, and never set overflow_o.
- R6: With mode_i = 1, a fire_i without read_i while count_o is at 2^CNT_W-1 is lost: count_o stays at the maximum and overflow_o goes to 1 at the next edge. overflow_o then stays 1 until reset.
- R7: not_empty_o is 1 exactly when mode_i = 1 and count_o is non-zero.
- R8: With IRQ_REGISTERED = 0, irq_o equals not_empty_o AND irq_en_i in the same cycle, so irq_o is always 0 in silent mode.
- R9: With mode_i = 0 (silent), fire_i and read_i have no effect on count_o or overflow_o, and not_empty_o is 0.
- R10: count_o shows the held count in both modes, so a count frozen in silent mode reappears unchanged when reporting resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 1 = reporting, 0 = silent |
| irq_en_i | input | 1 | Interrupt enable |
| fire_i | input | 1 | One-cycle pulse per firing of the transition |
| read_i | input | 1 | One-cycle pulse per report consumed by the host |
| count_o | output | CNT_W | Current number of pending reports |
| not_empty_o | output | 1 | Reports pending, in reporting mode only |
| irq_o | output | 1 | Interrupt request |
| overflow_o | output | 1 | Sticky flag: a firing was lost at saturation |

## Verification
The hardest case to reach from the ports is the saturation boundary. A fire must arrive exactly at the maximum count, and a fire paired with a read must arrive at that same count. The stimulus gets there by issuing 2^CNT_W-1 single fires in a row. It then probes the top with a combined fire and read, which must not overflow, and after that with a lone fire, which must. Then it reads one report and checks that the flag survives both the read and a switch to silent mode. A second mid-run reset confirms that only reset clears the flag.

// File: rtl/frq_pkg.sv
package frq_pkg;

   typedef enum logic {
      FRQ_SILENT = 1'b0,
      FRQ_REPORT = 1'b1
   } frq_mode_e;

   typedef enum logic [1:0] {
      FRQ_OP_HOLD = 2'd0,
      FRQ_OP_UP   = 2'd1,
      FRQ_OP_DOWN = 2'd2
   } frq_op_e;

   function automatic frq_op_e frq_decode(input logic up, input logic down);
      if (up && !down)
         return FRQ_OP_UP;
      else if (down && !up)
         return FRQ_OP_DOWN;
      else
         return FRQ_OP_HOLD;
   endfunction

endpackage

// File: rtl/frq_sat_counter.sv
module frq_sat_counter
   import frq_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             up,
   input  logic             down,
   output logic [CNT_W-1:0] cnt_o,
   output logic             at_zero_o,
   output logic             at_max_o,
   output logic             lost_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   frq_op_e          op;

   assign op        = en ? frq_decode(up, down) : FRQ_OP_HOLD;
   assign at_zero_o = (cnt_q == '0);
   assign at_max_o  = (cnt_q == CNT_MAX);
   assign lost_o    = (op == FRQ_OP_UP) && at_max_o;
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else begin
         case (op)
            FRQ_OP_UP:   if (!at_max_o)  cnt_q <= cnt_q + CNT_ONE;
            FRQ_OP_DOWN: if (!at_zero_o) cnt_q <= cnt_q - CNT_ONE;
            default:     cnt_q <= cnt_q;
         endcase
      end
   end

   assert_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && up && !down && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

   assert_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && down && !up && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

   assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && down && !up && (cnt_q == '0)) |=> (cnt_q == '0));

   assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up && down) |=> $stable(cnt_q));

   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q));

endmodule

// File: rtl/frq_sticky_flag.sv
module frq_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
   end

   assign flag_o = flag_q;

   assert_no_overflow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |=> flag_q);

   assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(set_i));

endmodule

// File: rtl/frq_irq_gen.sv
module frq_irq_gen #(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending_i,
   input  logic enable_i,
   output logic irq_o
);

   logic request;

   assign request = pending_i && enable_i;

   generate
      if (IRQ_REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= request;
         end
         assign irq_o = irq_q;

         assert_irq_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
            request |=> irq_o);
      end else begin : g_comb
         assign irq_o = request;

         always_comb begin
            if (rst_n)
               assert_irq_gate_R8: assert (!irq_o || pending_i);
         end
      end
   endgenerate

endmodule

// File: rtl/fire_report_queue.sv
module fire_report_queue
   import frq_pkg::*;
#(
   parameter int CNT_W          = 4,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic             irq_en_i,
   input  logic             fire_i,
   input  logic             read_i,
   output logic [CNT_W-1:0] count_o,
   output logic             not_empty_o,
   output logic             irq_o,
   output logic             overflow_o
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         initial $error("fire_report_queue: CNT_W must lie in 1..32");
      end
   endgenerate

   logic             reporting;
   logic [CNT_W-1:0] cnt;
   logic             at_zero;
   logic             at_max;
   logic             lost;

   assign reporting = (frq_mode_e'(mode_i) == FRQ_REPORT);

   frq_sat_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (reporting),
      .up        (fire_i),
      .down      (read_i),
      .cnt_o     (cnt),
      .at_zero_o (at_zero),
      .at_max_o  (at_max),
      .lost_o    (lost)
   );

   frq_sticky_flag u_ovf (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (lost),
      .flag_o (overflow_o)
   );

   assign not_empty_o = reporting && !at_zero;
   assign count_o     = cnt;

   frq_irq_gen #(
      .IRQ_REGISTERED (IRQ_REGISTERED)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending_i (not_empty_o),
      .enable_i  (irq_en_i),
      .irq_o     (irq_o)
   );

   assert_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_i |-> !not_empty_o);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && read_i && !overflow_o) |=> !overflow_o);

   assert_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && fire_i && !read_i && at_max) |=> (overflow_o && at_max));

   assert_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && (count_o != '0)) |-> not_empty_o);

endmodule

// File: tb/sim_fire_report_queue.sv
module sim_fire_report_queue;

   localparam int CNT_W  = 4;
   localparam int MAXV   = (1 << CNT_W) - 1;
   localparam int PERIOD = 8;

   typedef struct {
      int    cnt;
      bit    ne;
      bit    irq;
      bit    ovf;
      string req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_i = 1'b1;
   logic             irq_en_i = 1'b0;
   logic             fire_i = 1'b0;
   logic             read_i = 1'b0;
   logic [CNT_W-1:0] count_o;
   logic             not_empty_o;
   logic             irq_o;
   logic             overflow_o;

   int   checks = 0;
   int   errors = 0;
   int   m_cnt = 0;
   bit   m_ovf = 1'b0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #(PERIOD/2) clk = ~clk;

   fire_report_queue #(.CNT_W(CNT_W), .IRQ_REGISTERED(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .irq_en_i(irq_en_i),
      .fire_i(fire_i), .read_i(read_i), .count_o(count_o),
      .not_empty_o(not_empty_o), .irq_o(irq_o), .overflow_o(overflow_o));

   task automatic check_val(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare(input exp_t e);
      check_val(e.req, "count_o", int'(count_o), e.cnt);
      check_val(e.req, "not_empty_o", int'(not_empty_o), int'(e.ne));
      check_val(e.req, "irq_o", int'(irq_o), int'(e.irq));
      check_val(e.req, "overflow_o", int'(overflow_o), int'(e.ovf));
   endtask

   // driver: applies one cycle of stimulus and pushes the expected post-edge state
   task automatic step(input bit f, input bit r, input bit m, input bit ie, input string req);
      exp_t e;
      @(negedge clk);
      fire_i = f; read_i = r; mode_i = m; irq_en_i = ie;
      if (m) begin
         if (f && !r) begin
            if (m_cnt == MAXV) m_ovf = 1'b1;
            else m_cnt++;
         end else if (r && !f && m_cnt != 0) begin
            m_cnt--;
         end
      end
      e.cnt = m_cnt;
      e.ne  = m && (m_cnt != 0);
      e.irq = e.ne && ie;
      e.ovf = m_ovf;
      e.req = req;
      sb.push_back(e);
   endtask

   // monitor: samples after each rising edge, while inputs are still held
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) compare(sb.pop_front());
      end
   end

   task automatic do_reset(input string req);
      @(negedge clk);
      rst_n = 1'b0; fire_i = 1'b0; read_i = 1'b0; mode_i = 1'b1; irq_en_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check_val(req, "count_o in reset", int'(count_o), 0);
      check_val(req, "overflow_o in reset", int'(overflow_o), 0);
      check_val(req, "not_empty_o in reset", int'(not_empty_o), 0);
      check_val(req, "irq_o in reset", int'(irq_o), 0);
      m_cnt = 0; m_ovf = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset("R1");
      step(0, 0, 1, 0, "R1");
      // R2: increments, interrupt still disabled
      step(1, 0, 1, 0, "R2");
      step(1, 0, 1, 0, "R2");
      step(1, 0, 1, 0, "R2");
      // R8: enable, then disable interrupt
      step(0, 0, 1, 1, "R8");
      step(0, 0, 1, 0, "R8");
      // R3: reads
      step(0, 1, 1, 1, "R3");
      // R5: simultaneous at non-zero
      step(1, 1, 1, 1, "R5");
      step(0, 1, 1, 1, "R3");
      step(0, 1, 1, 1, "R3");
      // R4: read at zero
      step(0, 1, 1, 1, "R4");
      step(0, 1, 1, 1, "R4");
      // R5: simultaneous at zero
      step(1, 1, 1, 1, "R5");
      step(1, 0, 1, 1, "R7");
      step(1, 0, 1, 1, "R7");
      // R9: silent mode ignores fire and read
      step(0, 0, 0, 1, "R9");
      step(1, 0, 0, 1, "R9");
      step(0, 1, 0, 1, "R9");
      step(1, 0, 0, 1, "R9");
      // R10: held count returns in reporting mode
      step(0, 0, 1, 1, "R10");
      step(0, 1, 1, 1, "R10");
      step(0, 1, 1, 1, "R10");
      // R6: fill to maximum
      for (int i = 0; i < MAXV; i++) step(1, 0, 1, 1, "R2");
      step(1, 1, 1, 1, "R5");
      step(1, 0, 1, 1, "R6");
      step(1, 0, 1, 1, "R6");
      step(0, 1, 1, 1, "R6");
      step(1, 0, 0, 1, "R6");
      step(0, 0, 1, 0, "R6");
      repeat (3) @(negedge clk);
      do_reset("R1");
      step(0, 0, 1, 1, "R6");
      step(1, 0, 1, 1, "R2");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule